// File: doc/BRIEF.md
# IR Run-Length Carrier Transmitter

This block turns a stream of run-length codes from a host into an infrared drive signal. Each code byte describes one period of either carrier-on (mark) or carrier-off (space) lasting a whole number of 10 µs units. The host writes bytes through a small synchronous register port into a 16-entry queue. A sequencer pulls the bytes one after another with no gap between them. During marks it gates a square-wave carrier whose frequency is programmable from 30 to 60 kHz.

The host keeps the queue topped up by servicing a low-watermark interrupt. It closes a burst by issuing an end-of-burst command just before the final byte. Once that byte has been sent, a sticky completion flag rises. If the queue drains before a closing byte has been seen, an underrun flag is raised instead. The carrier is routed to one of four emitter outputs, and all outputs can have their polarity flipped. The host does the conversion from microseconds to units.

Register port map (write/read on `reg_addr`):
- Address 0: a write pushes a code byte; a read returns the queue fill count in bits 4:0.
- Address 1: a write is a command (bit 0 arms end-of-burst, bit 1 clears underrun, bit 2 clears the completion flag); a read returns status {closing, active, done, underrun} in bits 3:0.
- Address 2: configuration (bits 4:0 carrier code, bits 6:5 emitter select, bit 7 invert), readable.

Top module: `cir_burst_tx`

## Requirements
- R1: A code byte with bit 7 clear is a mark and with bit 7 set is a space. Bits 6:0 hold n, and the period lasts (n+1) units of CLK_KHZ/100 clocks, so the longest byte is 128 units.
- R2: Consecutive bytes of the same level form one unbroken period, and the carrier phase runs on across the byte boundary.
- R3: The queue holds 16 bytes, and its fill count reads at address 0. A push to a full queue is dropped and leaves the count at 16.
- R4: `irq_low` is high while a burst is active, no closing byte is queued, and at least 13 entries are free.
- R5: Writing command bit 0 tags the next pushed byte as the last one. The cycle after that byte's final clock, `irq_empty` rises and stays high until command bit 2 is written.
- R6: If an untagged byte finishes with the queue empty, `underrun` (status bit 0) is set and the burst ends. Command bit 1 clears it.
- R7: With carrier code c in config bits 4:0, the frequency is f = 30+c kHz, and codes 30 and 31 both give 60 kHz. Each half period lasts (CLK_KHZ+f)/(2f) clocks, and every mark run begins with an active half.
- R8: Config bits 6:5 pick which of the four outputs carries the signal. The other outputs stay at the idle level.
- R9: Config bit 7 inverts every output, so that the idle level becomes 1.
- R10: After reset the fill count is 0, status is 0, config reads 0x06 (36 kHz, output 0, no inversion), and all outputs and interrupts are low.
- R11: During a space the selected output stays at the idle level, with no carrier toggling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| ir_out | output | 4 | Emitter outputs |
| irq_low | output | 1 | Low-watermark interrupt (level) |
| irq_empty | output | 1 | Burst-complete flag (sticky) |
| underrun | output | 1 | Underrun flag (sticky) |

## Verification
A wrong unit counter or a wrong carrier divider shows at once in the selected output. It changes the number of active cycles, the number of rising edges, and the span from the first active cycle to the completion flag, all within the first byte. A carrier phase that restarts at a byte boundary changes the edge count of joined marks. A misplaced queue pointer or count shows in the fill count read the cycle after a push. The sweep covers every emitter, both polarities, the carrier table ends, and the full-queue drop.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int N_EMIT = 4;

    typedef struct packed {
        logic       last;   // closes the burst
        logic       space;  // 1 = space, 0 = mark
        logic [6:0] len;    // units minus one
    } tx_entry_t;

    typedef struct packed {
        logic       invert;
        logic [1:0] sel;
        logic [4:0] code;
    } tx_cfg_t;

    localparam tx_cfg_t CFG_RESET = '{invert: 1'b0, sel: 2'd0, code: 5'd6};

    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CMD  = 2'd1;
    localparam logic [1:0] A_CFG  = 2'd2;

    localparam int CMD_EOT       = 0;
    localparam int CMD_CLR_UR    = 1;
    localparam int CMD_CLR_EMPTY = 2;

    function automatic int carrier_khz(input int code);
        return (code >= 30) ? 60 : 30 + code;
    endfunction

    function automatic int half_cycles(input int clk_khz, input int code);
        int f;
        f = carrier_khz(code);
        return (clk_khz + f) / (2 * f);
    endfunction

endpackage

// File: rtl/cbt_fifo.sv
module cbt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 9,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign do_push = push && (count < CW'(DEPTH));
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) begin
                mem[wp] <= din;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (do_pop)
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r3_count_bounded: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH) && push && !pop) |=> count == CW'(DEPTH));

endmodule

// File: rtl/cbt_carrier.sv
module cbt_carrier #(
    parameter int CLK_KHZ = 1200,
    localparam int HW     = $clog2(CLK_KHZ / 60 + 2)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [4:0] code,
    output logic       phase
);
    import cbt_pkg::*;

    logic [HW-1:0] half_tbl [32];
    logic [HW-1:0] half, cnt;

    for (genvar g = 0; g < 32; g++) begin : g_tbl
        assign half_tbl[g] = HW'(half_cycles(CLK_KHZ, g));
    end

    assign half = half_tbl[code];

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt   <= '0;
            phase <= 1'b1;
        end else if (cnt >= half - 1'b1) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r7_armed_when_idle: assert property (@(posedge clk) disable iff (rst)
        !en |=> phase);

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq #(
    parameter int UNIT_CYC = 12,
    localparam int TW      = $clog2(UNIT_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               q_empty,
    input  cbt_pkg::tx_entry_t head,
    output logic               pop,
    output logic               mark,
    output logic               done_last,
    output logic               starve
);
    logic          run, space, last;
    logic [7:0]    units_left;
    logic [TW-1:0] tick;
    logic          unit_end, byte_end, load;

    assign unit_end  = run && (tick == TW'(UNIT_CYC - 1));
    assign byte_end  = unit_end && (units_left == 8'd1);
    assign load      = (!run || byte_end) && !q_empty;
    assign pop       = load;
    assign mark      = run && !space;
    assign done_last = byte_end && last;
    assign starve    = byte_end && !last && q_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            run        <= 1'b0;
            space      <= 1'b0;
            last       <= 1'b0;
            units_left <= '0;
            tick       <= '0;
        end else if (load) begin
            run        <= 1'b1;
            space      <= head.space;
            last       <= head.last;
            units_left <= {1'b0, head.len} + 8'd1;
            tick       <= '0;
        end else if (byte_end) begin
            run   <= 1'b0;
            space <= 1'b0;
            last  <= 1'b0;
            tick  <= '0;
        end else if (run) begin
            tick <= unit_end ? '0 : tick + 1'b1;
            if (unit_end)
                units_left <= units_left - 8'd1;
        end
    end

    a_r1_level_held: assert property (@(posedge clk) disable iff (rst)
        (run && !byte_end) |=> ($stable(space) && run));

    a_r1_units_nonzero: assert property (@(posedge clk) disable iff (rst)
        run |-> units_left != 8'd0);

endmodule

// File: rtl/cir_burst_tx.sv
module cir_burst_tx #(
    parameter int CLK_KHZ  = 1200,
    parameter int DEPTH    = 16,
    parameter int LOW_FREE = 13,
    localparam int UNIT_CYC = CLK_KHZ / 100,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [3:0] ir_out,
    output logic       irq_low,
    output logic       irq_empty,
    output logic       underrun
);
    import cbt_pkg::*;

    tx_cfg_t   cfg;
    tx_entry_t in_entry, head;
    logic [CW-1:0] fill;
    logic q_empty, push_req, push_ok, cmd_wr;
    logic eot_arm, closing, active;
    logic pop, mark, done_last, starve, phase, tx_bit;

    assign push_req = reg_wr && (reg_addr == A_DATA);
    assign push_ok  = push_req && (fill < CW'(DEPTH));
    assign cmd_wr   = reg_wr && (reg_addr == A_CMD);
    assign q_empty  = (fill == '0);
    assign in_entry = '{last: eot_arm, space: reg_wdata[7], len: reg_wdata[6:0]};

    cbt_fifo #(.DEPTH(DEPTH), .W($bits(tx_entry_t))) u_fifo (
        .clk(clk), .rst(rst), .push(push_req), .din(in_entry),
        .pop(pop), .dout(head), .count(fill)
    );

    cbt_seq #(.UNIT_CYC(UNIT_CYC)) u_seq (
        .clk(clk), .rst(rst), .q_empty(q_empty), .head(head),
        .pop(pop), .mark(mark), .done_last(done_last), .starve(starve)
    );

    cbt_carrier #(.CLK_KHZ(CLK_KHZ)) u_car (
        .clk(clk), .rst(rst), .en(mark), .code(cfg.code), .phase(phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= CFG_RESET;
            eot_arm   <= 1'b0;
            closing   <= 1'b0;
            active    <= 1'b0;
            irq_empty <= 1'b0;
            underrun  <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CFG)
                cfg <= tx_cfg_t'(reg_wdata);
            if (push_ok)
                eot_arm <= 1'b0;
            else if (cmd_wr && reg_wdata[CMD_EOT])
                eot_arm <= 1'b1;
            if (push_ok && eot_arm)
                closing <= 1'b1;
            else if (done_last)
                closing <= 1'b0;
            if (push_ok)
                active <= 1'b1;
            else if (done_last || starve)
                active <= 1'b0;
            if (done_last)
                irq_empty <= 1'b1;
            else if (cmd_wr && reg_wdata[CMD_CLR_EMPTY])
                irq_empty <= 1'b0;
            if (starve)
                underrun <= 1'b1;
            else if (cmd_wr && reg_wdata[CMD_CLR_UR])
                underrun <= 1'b0;
        end
    end

    assign irq_low = active && !closing && ((CW'(DEPTH) - fill) >= CW'(LOW_FREE));
    assign tx_bit  = mark && phase;

    for (genvar g = 0; g < N_EMIT; g++) begin : g_emit
        assign ir_out[g] = cfg.invert ^ (tx_bit && (cfg.sel == 2'(g)));
    end

    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = 8'(fill);
            A_CMD:   reg_rdata = {4'b0, closing, active, irq_empty, underrun};
            A_CFG:   reg_rdata = cfg;
            default: reg_rdata = 8'h00;
        endcase
    end

    a_r6_underrun_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(q_empty));

    a_r5_done_needs_close: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_empty) |-> $past(closing));

    a_r8_single_emitter: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ir_out ^ {N_EMIT{cfg.invert}}));

    a_r11_space_quiet: assert property (@(posedge clk) disable iff (rst)
        !mark |-> (ir_out == {N_EMIT{cfg.invert}}));

endmodule

// File: tb/sim_cir_burst_tx.sv
module sim_cir_burst_tx;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_KHZ    = 1200;
    localparam int UNIT       = CLK_KHZ / 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [3:0] ir_out;
    logic       irq_low, irq_empty, underrun;

    int total = 0;
    int bad   = 0;

    int meas = 0, sel_m = 0, inv_m = 0;
    int hi_cnt, rise_cnt, span, stray, started, prev;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cir_burst_tx #(.CLK_KHZ(CLK_KHZ)) u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ir_out(ir_out),
        .irq_low(irq_low), .irq_empty(irq_empty), .underrun(underrun)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        reg_addr = a;
        #1;
        v = int'(reg_rdata);
    endtask

    function automatic int half_of(input int code);
        int f;
        f = (code >= 30) ? 60 : 30 + code;
        return (CLK_KHZ + f) / (2 * f);
    endfunction

    function automatic int hi_model(input int d, input int h);
        int s = 0;
        for (int t = 0; t < d; t++)
            if ((t % (2 * h)) < h) s++;
        return s;
    endfunction

    always @(negedge clk) begin
        if (meas != 0) begin
            int b;
            b = int'(ir_out[sel_m]) ^ inv_m;
            if (!irq_empty) begin
                if (b != 0 && prev == 0) rise_cnt++;
                if (b != 0) hi_cnt++;
                if (started != 0 || b != 0) begin
                    started = 1;
                    span++;
                end
            end
            for (int k = 0; k < 4; k++)
                if (k != sel_m && int'(ir_out[k]) != inv_m) stray++;
            prev = b;
        end
    end

    task automatic wait_empty(output int ok);
        int n = 0;
        while (!irq_empty && n < 5000) begin
            @(negedge clk);
            n++;
        end
        ok = irq_empty ? 1 : 0;
    endtask

    // run: mark L1, mark L2, space S, mark L3 (last byte tagged)
    task automatic burst(input int code, input int sel, input int inv,
                         input int l1, input int l2, input int s, input int l3);
        int d12, d3, h, ok, v;
        wr(2'd2, 8'((inv << 7) | (sel << 5) | code));
        wr(2'd1, 8'h04);
        sel_m = sel; inv_m = inv;
        hi_cnt = 0; rise_cnt = 0; span = 0; stray = 0; started = 0; prev = 0;
        meas = 1;
        wr(2'd0, 8'(l1));
        wr(2'd0, 8'(l2));
        wr(2'd0, 8'(8'h80 | s));
        wr(2'd1, 8'h01);
        wr(2'd0, 8'(l3));
        chk(irq_low == 1'b0, "R4 low irq masked while closing", int'(irq_low), 0);
        wait_empty(ok);
        meas = 0;
        chk(ok == 1, "R5 completion flag", ok, 1);
        h   = half_of(code);
        d12 = (l1 + 1 + l2 + 1) * UNIT;
        d3  = (l3 + 1) * UNIT;
        chk(hi_cnt == hi_model(d12, h) + hi_model(d3, h), "R7 active cycles",
            hi_cnt, hi_model(d12, h) + hi_model(d3, h));
        chk(rise_cnt == (d12 + 2*h - 1) / (2*h) + (d3 + 2*h - 1) / (2*h),
            "R2 carrier edges across joined marks", rise_cnt,
            (d12 + 2*h - 1) / (2*h) + (d3 + 2*h - 1) / (2*h));
        chk(span == d12 + (s + 1) * UNIT + d3, "R1 burst span", span,
            d12 + (s + 1) * UNIT + d3);
        chk(stray == 0, "R8 R9 unselected outputs idle", stray, 0);
        chk(underrun == 1'b0, "R6 no underrun on closed burst", int'(underrun), 0);
        wr(2'd1, 8'h04);
        chk(irq_empty == 1'b0, "R5 flag cleared by command", int'(irq_empty), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v, ok, n;
        int codes[6] = '{0, 6, 13, 29, 30, 31};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R10 reset state
        rd(2'd0, v); chk(v == 0, "R10 fill after reset", v, 0);
        rd(2'd1, v); chk(v == 0, "R10 status after reset", v, 0);
        rd(2'd2, v); chk(v == 8'h06, "R10 config after reset", v, 6);
        chk(ir_out == 4'h0, "R10 outputs after reset", int'(ir_out), 0);
        chk({irq_low, irq_empty, underrun} == 3'b000, "R10 interrupts after reset",
            int'({irq_low, irq_empty, underrun}), 0);

        // R1 R2 R7 R8 R9 R11 sweep over carrier codes, emitters, polarity
        for (int ci = 0; ci < 6; ci++)
            for (int sel = 0; sel < 4; sel++) begin
                int i;
                i = ci * 4 + sel;
                burst(codes[ci], sel, i % 2, i % 3, (i % 5) + 1, i % 4, i % 2);
            end

        // R1 longest space byte, R11 no toggling during it
        wr(2'd2, 8'h06);
        hi_cnt = 0; rise_cnt = 0; span = 0; stray = 0; started = 0; prev = 0;
        sel_m = 0; inv_m = 0; meas = 1;
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'hFF);
        wait_empty(ok);
        meas = 0;
        chk(span == 129 * UNIT, "R1 longest byte span", span, 129 * UNIT);
        chk(rise_cnt == 1, "R11 space holds idle", rise_cnt, 1);
        chk(hi_cnt == hi_model(UNIT, half_of(6)), "R11 active cycles only in mark",
            hi_cnt, hi_model(UNIT, half_of(6)));
        wr(2'd1, 8'h04);

        // R3 R4 queue fill, watermark, drop on full
        wr(2'd0, 8'hFF);
        repeat (2) @(negedge clk);
        rd(2'd0, v); chk(v == 0, "R3 head taken by sequencer", v, 0);
        chk(irq_low == 1'b1, "R4 low irq with empty queue", int'(irq_low), 1);
        for (int k = 0; k < 3; k++) wr(2'd0, 8'h80);
        rd(2'd0, v); chk(v == 3, "R3 fill three", v, 3);
        chk(irq_low == 1'b1, "R4 low irq at 13 free", int'(irq_low), 1);
        wr(2'd0, 8'h80);
        chk(irq_low == 1'b0, "R4 low irq off at 12 free", int'(irq_low), 0);
        for (int k = 0; k < 12; k++) wr(2'd0, 8'h80);
        rd(2'd0, v); chk(v == 16, "R3 fill full", v, 16);
        wr(2'd0, 8'h80);
        rd(2'd0, v); chk(v == 16, "R3 push to full dropped", v, 16);

        // R6 underrun after drain
        n = 0;
        while (!underrun && n < 4000) begin
            @(negedge clk);
            n++;
        end
        chk(underrun == 1'b1, "R6 underrun raised", int'(underrun), 1);
        chk(irq_empty == 1'b0, "R6 no completion on underrun", int'(irq_empty), 0);
        rd(2'd1, v); chk(v == 1, "R6 status shows underrun only", v, 1);
        chk(irq_low == 1'b0, "R4 low irq off after burst ends", int'(irq_low), 0);
        wr(2'd1, 8'h02);
        chk(underrun == 1'b0, "R6 underrun cleared", int'(underrun), 0);
        rd(2'd1, v); chk(v == 0, "R6 status clear", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule